// File: doc/BRIEF.md
# Dual-Rail Precharged Substitution Box

This block computes a 6-to-4 substitution (the first DES substitution table) in a dual-rail precharged logic style. Every bit travels as a pair of wires, true and false. The block runs in two alternating phases. In precharge, every pair, from the registered inputs through the internal minterms to the outputs, rests at the spacer 00. In evaluation, each pair carries a complementary code: 10 means logic one and 01 means logic zero. Exactly one wire of every pair rises in each evaluation, so the number of switching wires does not depend on the data.

The logic uses only AND/OR gate pairs. The true half of an AND is an AND of true rails, and its false half is an OR of false rails. An OR gate is the mirror of this. A negation swaps the two wires and uses no inverter, so every node rises only from the spacer. A clocked phase register drives the two phases. The input pairs are captured on the edge that starts evaluation and are forced back to 00 on the edge that starts precharge. A monitor converts the output pairs to single-rail form. It flags a complete output code, flags any pair that reads 11, and keeps the true rails from the end of each valid evaluation.

Top module: `dr_sbox_top`

## Requirements
- R1: While rst_n is low, eval_ph is 0, both output rail vectors are 0, sr_data is 0, and sr_valid and rail_err are 0. Asserting rst_n in the middle of a run returns the block to this state.
- R2: After reset, eval_ph toggles on every rising clock edge, and its first value after reset is 1.
- R3: In every precharge cycle (eval_ph = 0), every output pair reads 00.
- R4: In an evaluation cycle whose captured input pairs are all complementary, dout_t equals S(x) and dout_f equals its bitwise complement. Here x is the value of the input true rails. S uses row = {x[5], x[0]} and column = x[4:1], with rows 0..3 over columns 0..15 as follows. Row 0: 14 4 13 1 2 15 11 8 3 10 6 12 5 9 0 7. Row 1: 0 15 7 4 14 2 13 1 10 6 12 11 9 5 3 8. Row 2: 4 1 14 8 13 6 2 11 15 12 9 7 3 10 5 0. Row 3: 15 12 8 2 4 9 1 7 5 11 3 14 10 0 6 13.
- R5: In such an evaluation cycle, exactly 4 of the 8 output wires are high, whatever the input value.
- R6: The input pairs are sampled only on the edge that ends a precharge cycle. A change of din_t or din_f during evaluation leaves the outputs unchanged.
- R7: sr_valid is 1 only in evaluation, and only when every output pair reads 01 or 10. An input pair held at 00 leaves sr_valid at 0.
- R8: rail_err is 1 whenever any output pair reads 11, for example when an input pair is driven to 11.
- R9: sr_data takes the output true rails on the edge that ends an evaluation with sr_valid = 1. After any other evaluation it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_t | input | 6 | Input true rails |
| din_f | input | 6 | Input false rails |
| eval_ph | output | 1 | 1 in evaluation, 0 in precharge |
| dout_t | output | 4 | Output true rails |
| dout_f | output | 4 | Output false rails |
| sr_data | output | 4 | Single-rail result of the last valid evaluation |
| sr_valid | output | 1 | All output pairs hold a complete code |
| rail_err | output | 1 | Some output pair reads 11 |

## Verification
The bench drives the input pairs at a falling edge of a precharge cycle. They are registered on the next rising edge, so the dual-rail outputs, sr_valid and rail_err are sampled at the falling edge one cycle after the stimulus. sr_data sits behind a second register, so it is sampled at the falling edge two cycles after the stimulus, which is also when the precharge spacer is checked. The R6 check changes the inputs in the middle of evaluation and samples again one nanosecond later, before any clock edge.

// File: rtl/dr_sbox_pkg.sv
`timescale 1ns/1ps
// Shared widths and the single-rail substitution table that the
// output plane is synthesised from. Assumes a 6-bit input and 4-bit output.
package dr_sbox_pkg;
    localparam int SB_IN_W  = 6;
    localparam int SB_OUT_W = 4;

    localparam logic [3:0] SB_ROWS [4][16] = '{
        '{4'd14, 4'd4,  4'd13, 4'd1,  4'd2,  4'd15, 4'd11, 4'd8,
          4'd3,  4'd10, 4'd6,  4'd12, 4'd5,  4'd9,  4'd0,  4'd7},
        '{4'd0,  4'd15, 4'd7,  4'd4,  4'd14, 4'd2,  4'd13, 4'd1,
          4'd10, 4'd6,  4'd12, 4'd11, 4'd9,  4'd5,  4'd3,  4'd8},
        '{4'd4,  4'd1,  4'd14, 4'd8,  4'd13, 4'd6,  4'd2,  4'd11,
          4'd15, 4'd12, 4'd9,  4'd7,  4'd3,  4'd10, 4'd5,  4'd0},
        '{4'd15, 4'd12, 4'd8,  4'd2,  4'd4,  4'd9,  4'd1,  4'd7,
          4'd5,  4'd11, 4'd3,  4'd14, 4'd10, 4'd0,  4'd6,  4'd13}
    };

    // Row is formed from the outer bits, column from the inner four.
    function automatic logic [3:0] sb_lookup(input logic [5:0] x);
        logic [1:0] row;
        logic [3:0] col;
        row = {x[5], x[0]};
        col = x[4:1];
        return SB_ROWS[row][col];
    endfunction
endpackage

// File: rtl/dr_phase_reg.sv
`timescale 1ns/1ps
// Phase generator and dual-rail input register.
// Assumes: the phase toggles every clock; inputs are captured only when
// leaving precharge and forced to the 00 spacer when leaving evaluation.
module dr_phase_reg #(
    parameter int IN_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] din_t,
    input  logic [IN_W-1:0] din_f,
    output logic            eval_o,
    output logic [IN_W-1:0] in_t_o,
    output logic [IN_W-1:0] in_f_o
);
    // Toggle the phase and load or clear the input pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eval_o <= 1'b0;
            in_t_o <= '0;
            in_f_o <= '0;
        end else begin
            eval_o <= ~eval_o;
            if (!eval_o) begin
                in_t_o <= din_t;
                in_f_o <= din_f;
            end else begin
                in_t_o <= '0;
                in_f_o <= '0;
            end
        end
    end
endmodule

// File: rtl/dr_minterm_plane.sv
`timescale 1ns/1ps
// Full dual-rail decoder: one AND/OR pair per input code.
// A literal for a zero bit uses swapped rails instead of an inverter,
// so every minterm pair stays 00 while the inputs are 00.
module dr_minterm_plane #(
    parameter int IN_W = 6,
    localparam int NUM_MT = 1 << IN_W
) (
    input  logic [IN_W-1:0]   in_t,
    input  logic [IN_W-1:0]   in_f,
    output logic [NUM_MT-1:0] mt_t,
    output logic [NUM_MT-1:0] mt_f
);
    for (genvar m = 0; m < NUM_MT; m++) begin : g_mt
        localparam logic [IN_W-1:0] CODE = IN_W'(m);
        logic [IN_W-1:0] lit_t;
        logic [IN_W-1:0] lit_f;
        // Pick true or swapped rails per bit, then form the gate pair.
        always_comb begin
            for (int b = 0; b < IN_W; b++) begin
                lit_t[b] = CODE[b] ? in_t[b] : in_f[b];
                lit_f[b] = CODE[b] ? in_f[b] : in_t[b];
            end
            mt_t[m] = &lit_t;
            mt_f[m] = |lit_f;
        end
    end
endmodule

// File: rtl/dr_or_plane.sv
`timescale 1ns/1ps
// Output plane: each output true rail ORs the minterm true rails whose
// table entry has that bit set; the false rail ANDs their false rails.
// Assumes every output bit is 1 for at least one table entry.
module dr_or_plane #(
    parameter int IN_W  = 6,
    parameter int OUT_W = 4,
    localparam int NUM_MT = 1 << IN_W
) (
    input  logic [NUM_MT-1:0] mt_t,
    input  logic [NUM_MT-1:0] mt_f,
    output logic [OUT_W-1:0]  out_t,
    output logic [OUT_W-1:0]  out_f
);
    import dr_sbox_pkg::*;

    logic [OUT_W-1:0] entry;

    // Accumulate the dual OR/AND trees over the table contents.
    always_comb begin
        out_t = '0;
        out_f = '1;
        entry = '0;
        for (int m = 0; m < NUM_MT; m++) begin
            entry = OUT_W'(sb_lookup(6'(m)));
            for (int j = 0; j < OUT_W; j++) begin
                if (entry[j]) begin
                    out_t[j] = out_t[j] | mt_t[m];
                    out_f[j] = out_f[j] & mt_f[m];
                end
            end
        end
    end
endmodule

// File: rtl/dr_rail_monitor.sv
`timescale 1ns/1ps
// Single-rail converter: flags complete and illegal output codes, and
// keeps the true rails of each complete evaluation.
module dr_rail_monitor #(
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic [OUT_W-1:0] out_t,
    input  logic [OUT_W-1:0] out_f,
    output logic             valid,
    output logic             err,
    output logic [OUT_W-1:0] sr_q
);
    // Completion and illegal-code detection.
    always_comb begin
        valid = eval & (&(out_t ^ out_f));
        err   = |(out_t & out_f);
    end

    // Capture the result on the edge that closes a valid evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (valid) sr_q <= out_t;
    end
endmodule

// File: rtl/dr_sbox_top.sv
`timescale 1ns/1ps
// Dual-rail precharged 6-to-4 substitution box.
// Assumes the caller drives complementary input pairs while eval_ph is 0.
module dr_sbox_top #(
    parameter int IN_W  = dr_sbox_pkg::SB_IN_W,
    parameter int OUT_W = dr_sbox_pkg::SB_OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din_t,
    input  logic [IN_W-1:0]  din_f,
    output logic             eval_ph,
    output logic [OUT_W-1:0] dout_t,
    output logic [OUT_W-1:0] dout_f,
    output logic [OUT_W-1:0] sr_data,
    output logic             sr_valid,
    output logic             rail_err
);
    localparam int NUM_MT = 1 << IN_W;

    logic [IN_W-1:0]   in_t_q;
    logic [IN_W-1:0]   in_f_q;
    logic [NUM_MT-1:0] mt_t;
    logic [NUM_MT-1:0] mt_f;

    dr_phase_reg #(.IN_W(IN_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .din_t(din_t), .din_f(din_f),
        .eval_o(eval_ph), .in_t_o(in_t_q), .in_f_o(in_f_q)
    );

    dr_minterm_plane #(.IN_W(IN_W)) u_mt (
        .in_t(in_t_q), .in_f(in_f_q), .mt_t(mt_t), .mt_f(mt_f)
    );

    dr_or_plane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_or (
        .mt_t(mt_t), .mt_f(mt_f), .out_t(dout_t), .out_f(dout_f)
    );

    dr_rail_monitor #(.OUT_W(OUT_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .eval(eval_ph), .out_t(dout_t),
        .out_f(dout_f), .valid(sr_valid), .err(rail_err), .sr_q(sr_data)
    );
endmodule

// File: rtl/dr_sbox_chk.sv
`timescale 1ns/1ps
// Protocol checker for dr_sbox_top, attached by bind.
module dr_sbox_chk #(
    parameter int IN_W  = 6,
    parameter int OUT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval_ph,
    input logic [IN_W-1:0]  in_t_q,
    input logic [IN_W-1:0]  in_f_q,
    input logic [OUT_W-1:0] dout_t,
    input logic [OUT_W-1:0] dout_f,
    input logic [OUT_W-1:0] sr_data,
    input logic             sr_valid,
    input logic             rail_err
);
    p_phase_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_ph |=> eval_ph);
    p_phase_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_ph |=> !eval_ph);
    p_spacer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_ph |-> ((dout_t | dout_f) == '0 && (in_t_q | in_f_q) == '0));
    p_const_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_ph && (in_t_q ^ in_f_q) == '1)
        |-> ($countones({dout_t, dout_f}) == OUT_W && sr_valid));
    p_valid_in_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_valid |-> eval_ph);
    p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rail_err |-> !sr_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_valid |=> $stable(sr_data));
endmodule

bind dr_sbox_top dr_sbox_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .eval_ph(eval_ph), .in_t_q(in_t_q),
    .in_f_q(in_f_q), .dout_t(dout_t), .dout_f(dout_f), .sr_data(sr_data),
    .sr_valid(sr_valid), .rail_err(rail_err)
);

// File: tb/dr_sbox_top_tb_top.sv
`timescale 1ns/1ps
module dr_sbox_top_tb_top;
    localparam logic [3:0] EXP_TAB [4][16] = '{
        '{4'd14, 4'd4,  4'd13, 4'd1,  4'd2,  4'd15, 4'd11, 4'd8,
          4'd3,  4'd10, 4'd6,  4'd12, 4'd5,  4'd9,  4'd0,  4'd7},
        '{4'd0,  4'd15, 4'd7,  4'd4,  4'd14, 4'd2,  4'd13, 4'd1,
          4'd10, 4'd6,  4'd12, 4'd11, 4'd9,  4'd5,  4'd3,  4'd8},
        '{4'd4,  4'd1,  4'd14, 4'd8,  4'd13, 4'd6,  4'd2,  4'd11,
          4'd15, 4'd12, 4'd9,  4'd7,  4'd3,  4'd10, 4'd5,  4'd0},
        '{4'd15, 4'd12, 4'd8,  4'd2,  4'd4,  4'd9,  4'd1,  4'd7,
          4'd5,  4'd11, 4'd3,  4'd14, 4'd10, 4'd0,  4'd6,  4'd13}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] din_t = '0;
    logic [5:0] din_f = '0;
    logic       eval_ph;
    logic [3:0] dout_t, dout_f, sr_data;
    logic       sr_valid, rail_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dr_sbox_top dut_i (
        .clk(clk), .rst_n(rst_n), .din_t(din_t), .din_f(din_f),
        .eval_ph(eval_ph), .dout_t(dout_t), .dout_f(dout_f),
        .sr_data(sr_data), .sr_valid(sr_valid), .rail_err(rail_err)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [3:0] ref_s(input logic [5:0] x);
        return EXP_TAB[{x[5], x[0]}][x[4:1]];
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
        end
    end

    initial begin
        logic [3:0] last;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(eval_ph == 1'b0, "R1 phase", 32'(eval_ph), 0);
        chk({dout_t, dout_f} == '0, "R1 rails", 32'({dout_t, dout_f}), 0);
        chk({sr_data, sr_valid, rail_err} == '0, "R1 sr", 32'({sr_data, sr_valid, rail_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(eval_ph == 1'b1, "R2 first phase", 32'(eval_ph), 1);
        @(negedge clk);
        last = '0;
        // Walk all 64 codes; each takes one precharge and one evaluation.
        for (int v = 0; v < 64; v++) begin
            logic [5:0] x;
            logic [3:0] e;
            x = 6'(v);
            e = ref_s(x);
            chk(eval_ph == 1'b0, "R2 precharge", 32'(eval_ph), 0);
            din_t = x;
            din_f = ~x;
            @(negedge clk);
            chk(eval_ph == 1'b1, "R2 evaluation", 32'(eval_ph), 1);
            chk(dout_t == e && dout_f == ~e, "R4 map",
                32'({dout_t, dout_f}), 32'({e, ~e}));
            chk($countones({dout_t, dout_f}) == 4, "R5 rise count",
                32'($countones({dout_t, dout_f})), 4);
            chk(sr_valid && !rail_err, "R7 valid", 32'({sr_valid, rail_err}), 2);
            din_t = ~x;
            din_f = x;
            #1;
            chk(dout_t == e && dout_f == ~e, "R6 ignored", 32'({dout_t, dout_f}), 32'({e, ~e}));
            @(negedge clk);
            chk({dout_t, dout_f} == '0, "R3 spacer", 32'({dout_t, dout_f}), 0);
            chk(sr_data == e, "R9 capture", 32'(sr_data), 32'(e));
            last = e;
        end
        // R7: incomplete input pair (bit 1 at 00)
        din_t = 6'b000000;
        din_f = 6'b111101;
        @(negedge clk);
        chk(!sr_valid && !rail_err, "R7 incomplete", 32'({sr_valid, rail_err}), 0);
        chk(dout_t == 4'h0 && dout_f == 4'h1, "R7 partial rails",
            32'({dout_t, dout_f}), 32'h01);
        @(negedge clk);
        chk(sr_data == last, "R9 hold incomplete", 32'(sr_data), 32'(last));
        // R8: illegal input pair (bit 1 at 11)
        din_t = 6'b000010;
        din_f = 6'b111111;
        @(negedge clk);
        chk(rail_err && !sr_valid, "R8 error", 32'({rail_err, sr_valid}), 2);
        chk(dout_t == 4'hE && dout_f == 4'hF, "R8 rails", 32'({dout_t, dout_f}), 32'hEF);
        @(negedge clk);
        chk(sr_data == last, "R9 hold error", 32'(sr_data), 32'(last));
        chk(!rail_err && {dout_t, dout_f} == '0, "R3 spacer after error",
            32'({rail_err, dout_t, dout_f}), 0);
        // R1: reset in the middle of an evaluation
        din_t = 6'd5;
        din_f = ~6'd5;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(eval_ph == 1'b0 && sr_data == '0, "R1 mid reset", 32'({eval_ph, sr_data}), 0);
        chk({dout_t, dout_f, sr_valid, rail_err} == '0, "R1 mid reset rails",
            32'({dout_t, dout_f, sr_valid, rail_err}), 0);
        done = 1'b1;
        summary();
    end
endmodule